// File: doc/BRIEF.md
# Chip-Enable Gate with Reset Hold-Over

This block sits between a host's active-low chip-enable request and a memory device. While the supply is reported good and the supervisor's reset is released, the request passes straight through to the output in the same cycle. As soon as either the supply-good flag drops or the supervisor reset asserts, the block treats the system as being in reset and blocks the enable. The output is then held high.

Blocking every access at once could corrupt a write that is already under way. If the request is low on the very cycle that reset begins, the output is therefore allowed to stay low for a bounded hold-over window of `HOLD_CYCLES` clock cycles. The window closes early if the host releases the request. It also closes early when a qualified manual-reset pulse arrives. Once the window has closed, the output stays blocked until reset is over. A synchronous power-on clear puts the block into a known state.

Top module: `ce_holdover_gate`

## Requirements
- R1: When `supply_ok` is 1 and `sup_rst_n` is 1, with no clear and no manual pulse, `ce_out_n` equals `ce_req_n` in the same cycle.
- R2: The system is in reset whenever `sup_rst_n` is 0 or `supply_ok` is 0. In reset, `ce_out_n` is 1 except inside a hold-over window, and `ce_out_n` is never 0 while `ce_req_n` is 1.
- R3: If `ce_req_n` is 0 on the first cycle in reset, `ce_out_n` stays 0 for exactly `HOLD_CYCLES` cycles, counting that first cycle, and is 1 afterwards.
- R4: Inside the window, a cycle with `ce_req_n` at 1 ends the window. `ce_out_n` stays 1 for the rest of that reset episode, even if the request returns to 0.
- R5: If the request is 1 on the first cycle in reset, no window opens. A later falling edge of `ce_req_n` in the same reset episode leaves `ce_out_n` at 1.
- R6: While `mr_pulse` is 1, `ce_out_n` is 1 in that same cycle. A pulse during a window ends the window for the rest of the episode.
- R7: While `por_clr` is 1, `ce_out_n` is 1 and the window state is cleared. A reset already active when the clear is released opens no window.
- R8: When reset ends, the pass-through of R1 resumes with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all inputs |
| por_clr | input | 1 | Synchronous power-on clear, active high |
| ce_req_n | input | 1 | Host chip-enable request, active low |
| supply_ok | input | 1 | Supply above reset threshold |
| sup_rst_n | input | 1 | Supervisor reset, active low |
| mr_pulse | input | 1 | Qualified manual-reset pulse, active high |
| ce_out_n | output | 1 | Gated chip-enable to memory, active low |

## Verification
The hold-over is swept over every release point of the request, from before reset onset to beyond the window. This separates the early-end case from the full-length window and pins the window length to exactly `HOLD_CYCLES`. The same sweep is repeated with a manual pulse arriving at each offset, and each sweep is run twice: once with the supervisor reset as the onset source and once with the supply flag. Further patterns cover a request that falls again after the window, onset with the request already high, steady pass-through with both levels, and reset still held at the moment the clear is released.

// File: rtl/ce_holdover_gate.sv
module ce_holdover_gate #(
  parameter int HOLD_CYCLES = 3750
) (
  input  logic clk,
  input  logic por_clr,
  input  logic ce_req_n,
  input  logic supply_ok,
  input  logic sup_rst_n,
  input  logic mr_pulse,
  output logic ce_out_n
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic          in_rst;
  logic          was_rst;
  logic          hold_q;
  logic [CW-1:0] used_q;
  logic          onset;
  logic          win;

  assign in_rst = !sup_rst_n || !supply_ok;
  assign onset  = in_rst && !was_rst;
  assign win    = in_rst && !ce_req_n && !mr_pulse && !por_clr &&
                  (onset || (hold_q && used_q < LIMIT));

  always_ff @(posedge clk) begin
    if (por_clr) begin
      was_rst <= 1'b1;
      hold_q  <= 1'b0;
      used_q  <= '0;
    end else begin
      was_rst <= in_rst;
      if (win) begin
        hold_q <= 1'b1;
        used_q <= onset ? CW'(1) : used_q + CW'(1);
      end else begin
        hold_q <= 1'b0;
        used_q <= '0;
      end
    end
  end

  assign ce_out_n = por_clr || mr_pulse || (in_rst ? !win : ce_req_n);

endmodule

module ce_holdover_gate_chk #(
  parameter int HOLD_CYCLES = 3750
) (
  input logic clk,
  input logic por_clr,
  input logic ce_req_n,
  input logic supply_ok,
  input logic sup_rst_n,
  input logic mr_pulse,
  input logic ce_out_n
);

  logic        rst_c;
  logic [31:0] low_run;

  assign rst_c = !sup_rst_n || !supply_ok;

  always_ff @(posedge clk) begin
    if (por_clr || !rst_c || ce_out_n) low_run <= 0;
    else                               low_run <= low_run + 1;
  end

  a_r1_pass: assert property (@(posedge clk) disable iff (por_clr)
    (!rst_c && !mr_pulse) |-> (ce_out_n == ce_req_n));

  a_r2_req_needed: assert property (@(posedge clk) disable iff (por_clr)
    ce_req_n |-> ce_out_n);

  a_r3_window_bound: assert property (@(posedge clk) disable iff (por_clr)
    (rst_c && !ce_out_n && !$past(por_clr)) |-> (low_run < 32'(HOLD_CYCLES)));

  a_r5_no_restart: assert property (@(posedge clk) disable iff (por_clr)
    (rst_c && $past(rst_c) && $past(ce_out_n)) |-> ce_out_n);

  a_r6_mr_blocks: assert property (@(posedge clk) disable iff (por_clr)
    mr_pulse |-> ce_out_n);

  a_r7_clear_high: assert property (@(posedge clk)
    por_clr |-> ce_out_n);

endmodule

bind ce_holdover_gate ce_holdover_gate_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
  .clk(clk), .por_clr(por_clr), .ce_req_n(ce_req_n), .supply_ok(supply_ok),
  .sup_rst_n(sup_rst_n), .mr_pulse(mr_pulse), .ce_out_n(ce_out_n)
);

// File: tb/ce_holdover_gate_tb.sv
module ce_holdover_gate_tb_top;
  localparam int H = 5;

  logic clk = 1'b0;
  logic por_clr, ce_req_n, supply_ok, sup_rst_n, mr_pulse;
  logic ce_out_n;
  int compared = 0;
  int mism = 0;

  always #2 clk = ~clk;

  ce_holdover_gate #(.HOLD_CYCLES(H)) dut_i (
    .clk(clk), .por_clr(por_clr), .ce_req_n(ce_req_n), .supply_ok(supply_ok),
    .sup_rst_n(sup_rst_n), .mr_pulse(mr_pulse), .ce_out_n(ce_out_n)
  );

  task automatic drive(input logic clr, input logic req, input logic sok,
                       input logic rn, input logic mr);
    @(negedge clk);
    por_clr = clr; ce_req_n = req; supply_ok = sok; sup_rst_n = rn; mr_pulse = mr;
    #1;
  endtask

  task automatic chk(input logic exp, input string tag);
    compared++;
    if (ce_out_n !== exp) begin
      mism++;
      $display("FAIL %s: ce_out_n=%b expected %b", tag, ce_out_n, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  endtask

  // One reset episode: src=0 uses sup_rst_n, src=1 uses supply_ok.
  // Request released at offset r, manual pulse at offset m.
  task automatic episode(input int src, input int r, input int m);
    logic sok, rn, req, mr, exp;
    drive(0, 1'b0, 1, 1, 0); chk(1'b0, "R1 pass low");
    drive(0, 1'b1, 1, 1, 0); chk(1'b1, "R1 pass high");
    drive(0, 1'b0, 1, 1, 0); chk(1'b0, "R1 pass low");
    sok = (src == 1) ? 1'b0 : 1'b1;
    rn  = (src == 0) ? 1'b0 : 1'b1;
    for (int k = 0; k < H + 3; k++) begin
      req = (k >= r);
      mr  = (k == m);
      exp = !(k < H && k < r && k < m);
      drive(0, req, sok, rn, mr);
      if (m < H + 3) chk(exp, "R6 pulse in window");
      else if (r == 0) chk(exp, "R5 onset with request high");
      else if (r < H) chk(exp, "R4 early end");
      else chk(exp, "R3 window length");
    end
    drive(0, 1'b1, sok, rn, 0); chk(1'b1, "R2 blocked high");
    drive(0, 1'b0, sok, rn, 0); chk(1'b1, "R5 no restart");
    drive(0, 1'b0, sok, rn, 0); chk(1'b1, "R2 blocked low req");
    drive(0, 1'b0, 1, 1, 0);    chk(1'b0, "R8 resume");
    drive(0, 1'b1, 1, 1, 0);    chk(1'b1, "R8 resume high");
  endtask

  initial begin
    #400000;
    mism++;
    $display("FAIL watchdog: ce_out_n=%b expected run end", ce_out_n);
    finish_run();
  end

  initial begin
    drive(1, 1'b0, 1, 1, 0); chk(1'b1, "R7 clear forces high");
    drive(1, 1'b0, 0, 0, 0); chk(1'b1, "R7 clear in reset");
    drive(0, 1'b0, 0, 0, 0); chk(1'b1, "R7 no window after clear");
    drive(0, 1'b0, 0, 0, 0); chk(1'b1, "R7 no window after clear");
    drive(0, 1'b0, 1, 1, 0); chk(1'b0, "R8 pass after reset");
    drive(0, 1'b0, 1, 1, 1); chk(1'b1, "R6 pulse outside reset");

    for (int src = 0; src < 2; src++) begin
      for (int r = 0; r <= H + 2; r++) episode(src, r, 99);
      for (int m = 0; m <= H + 1; m++) episode(src, 99, m);
    end

    drive(0, 1'b0, 1, 1, 0);
    drive(0, 1'b0, 0, 0, 0);
    drive(1, 1'b0, 0, 0, 0); chk(1'b1, "R7 clear ends window");
    drive(0, 1'b0, 0, 0, 0); chk(1'b1, "R7 window cleared");
    finish_run();
  end
endmodule